// File: doc/BRIEF.md
# Simultaneous Multi-Converter Capture Sequencer

This block drives a group of external byte-wide sampling converters that must all capture at the same instant. On a host request it pulls one shared start strobe and one shared chip-select low, so every converter begins converting in the same cycle. It then watches the active-low end-of-conversion lines of all converters and holds off any readout until the whole group has finished.

After the group completes, the block reads the converters one by one in ascending index order over a shared data bus with an index select. Each byte goes to the matching location of a small result buffer, starting at offset 0. When the last converter has been stored, a one-cycle done pulse goes to the host and the index returns to zero for the next request. The converter count, data width, strobe width and read access time are parameters, so larger groups need only a wider select.

Top module: `adc_capture_seq`

## Requirements
- R1: After reset, `conv_cs_no`, `conv_wr_no` and `conv_rd_no` are high (1), and `done_o` and `buf_we_o` are low.
- R2: A `start_i` pulse sampled while idle drives `conv_wr_no` and `conv_cs_no` low together for exactly `START_CYC` cycles (`START_CYC` at least 2). `conv_wr_no` is never low while `conv_cs_no` is high.
- R3: `eoc_ni` bits are active low (0 = conversion complete). They pass through a two-flop synchronizer. After the strobe, the block first waits until every bit reads 1 and then until every bit reads 0. The first read starts 3 cycles after the last `eoc_ni` bit falls.
- R4: Reads use converter indices 0, 1, ..., N_CONV-1 in that order. Each read holds `conv_cs_no` and `conv_rd_no` low with `conv_sel_o` equal to the index for `ACC_CYC` cycles, and samples `conv_data_i` in the last of them.
- R5: Each sampled byte is written to the buffer with a one-cycle `buf_we_o` pulse, `buf_addr_o` equal to the converter index and `buf_data_o` equal to the sampled byte.
- R6: `done_o` is high for exactly one cycle per request, in the same cycle as the write to address N_CONV-1.
- R7: A `start_i` received while a capture is in progress is ignored. Each request yields exactly one strobe and exactly N_CONV buffer writes, and no activity follows `done_o`.
- R8: After `done_o`, the read index is back at 0, so the next request again writes from buffer address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture request from host |
| done_o | output | 1 | One-cycle capture-complete pulse |
| conv_cs_no | output | 1 | Shared converter chip select, active low |
| conv_wr_no | output | 1 | Shared start-conversion strobe, active low |
| conv_rd_no | output | 1 | Read enable, active low |
| conv_sel_o | output | SELW | Index of converter being read |
| conv_data_i | input | DW | Converter data bus |
| eoc_ni | input | N_CONV | Per-converter end of conversion, active low |
| buf_we_o | output | 1 | Result buffer write enable |
| buf_addr_o | output | SELW | Result buffer address |
| buf_data_o | output | DW | Result buffer write data |

## Verification
The assertions check on every cycle that the strobe only appears under chip select and never overlaps a read, that the strobe lasts its full width, that readout starts only from a state where all synchronized completion lines were low, that successive buffer addresses step by one, and that done is a single-cycle pulse coincident with the last write. Only the bench's scenarios can show the whole sequence against a converter model: the exact delay from the last completion edge to the first read, the byte sampled for each index, that a repeated request is ignored, and that a completion left over from a previous conversion does not trigger an early readout. The bench sweeps which converter finishes last and several staggered delay patterns.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_ARM,
    S_WAIT,
    S_READ
  } seq_state_e;
endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
  parameter int N_CONV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CONV-1:0] eoc_ni,
  output logic              all_busy_o,
  output logic              all_done_o
);
  logic [N_CONV-1:0] s1_q, s2_q;

  for (genvar g = 0; g < N_CONV; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b1;
        s2_q[g] <= 1'b1;
      end else begin
        s1_q[g] <= eoc_ni[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  assign all_busy_o = &s2_q;
  assign all_done_o = ~|s2_q;

  a_r3_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(all_busy_o && all_done_o));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_CONV    = 8,
  parameter int DW        = 8,
  parameter int START_CYC = 2,
  parameter int ACC_CYC   = 2,
  localparam int SELW = (N_CONV > 1) ? $clog2(N_CONV) : 1,
  localparam int CMAX = (START_CYC > ACC_CYC) ? START_CYC : ACC_CYC,
  localparam int CW   = $clog2(CMAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            all_busy_i,
  input  logic            all_done_i,
  input  logic [DW-1:0]   data_i,
  output logic            cs_no,
  output logic            wr_no,
  output logic            rd_no,
  output logic [SELW-1:0] sel_o,
  output logic            we_o,
  output logic [SELW-1:0] addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            done_o
);
  localparam logic [SELW-1:0] LAST   = SELW'(N_CONV - 1);
  localparam logic [CW-1:0]   ST_END = CW'(START_CYC - 1);
  localparam logic [CW-1:0]   AC_END = CW'(ACC_CYC - 1);

  seq_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic [SELW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      we_o    <= 1'b0;
      done_o  <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o   <= 1'b0;
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_START;
          cnt_q   <= '0;
        end
        S_START: begin
          if (cnt_q == ST_END) state_q <= S_ARM;
          else                 cnt_q   <= cnt_q + 1'b1;
        end
        // wait for every converter to drop a stale completion
        S_ARM: if (all_busy_i) state_q <= S_WAIT;
        S_WAIT: if (all_done_i) begin
          state_q <= S_READ;
          cnt_q   <= '0;
        end
        S_READ: begin
          if (cnt_q == AC_END) begin
            cnt_q   <= '0;
            we_o    <= 1'b1;
            addr_o  <= idx_q;
            wdata_o <= data_i;
            if (idx_q == LAST) begin
              idx_q   <= '0;
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_no = (state_q != S_START);
  assign rd_no = (state_q != S_READ);
  assign cs_no = !((state_q == S_START) || (state_q == S_READ));
  assign sel_o = idx_q;

  initial a_r2_min_width: assert (START_CYC >= 2);

  a_r2_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START && cnt_q < ST_END) |=> (state_q == S_START));
  a_r3_read_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_READ && $past(state_q) == S_WAIT) |-> $past(all_done_i));
  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !done_o) |-> (idx_q == addr_o + 1'b1));
  a_r6_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (we_o && addr_o == LAST));
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_idx_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (idx_q == '0));
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq #(
  parameter int N_CONV    = 8,
  parameter int DW        = 8,
  parameter int START_CYC = 2,
  parameter int ACC_CYC   = 2,
  localparam int SELW = (N_CONV > 1) ? $clog2(N_CONV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              conv_cs_no,
  output logic              conv_wr_no,
  output logic              conv_rd_no,
  output logic [SELW-1:0]   conv_sel_o,
  input  logic [DW-1:0]     conv_data_i,
  input  logic [N_CONV-1:0] eoc_ni,
  output logic              buf_we_o,
  output logic [SELW-1:0]   buf_addr_o,
  output logic [DW-1:0]     buf_data_o
);
  logic all_busy, all_done;

  adc_eoc_sync #(.N_CONV(N_CONV)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eoc_ni     (eoc_ni),
    .all_busy_o (all_busy),
    .all_done_o (all_done)
  );

  adc_seq_ctrl #(
    .N_CONV(N_CONV), .DW(DW), .START_CYC(START_CYC), .ACC_CYC(ACC_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .all_busy_i (all_busy),
    .all_done_i (all_done),
    .data_i     (conv_data_i),
    .cs_no      (conv_cs_no),
    .wr_no      (conv_wr_no),
    .rd_no      (conv_rd_no),
    .sel_o      (conv_sel_o),
    .we_o       (buf_we_o),
    .addr_o     (buf_addr_o),
    .wdata_o    (buf_data_o),
    .done_o     (done_o)
  );

  a_r2_wr_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_wr_no |-> !conv_cs_no);
  a_r4_no_rd_during_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!conv_rd_no && !conv_wr_no));
endmodule

// File: tb/adc_capture_seq_test.sv
module adc_capture_seq_test;
  localparam int N   = 8;
  localparam int DW  = 8;
  localparam int STC = 2;
  localparam int ACC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, cs_n, wr_n, rd_n, we;
  logic [2:0] sel, addr;
  logic [DW-1:0] din, bdata;
  logic [N-1:0] eoc_n = '0; // stale completion from an earlier conversion

  int tests = 0, fails = 0, cyc = 0, last_fall = 0, run_id = 0;
  int dly [N];
  int cnt [N];

  always #5 clk = ~clk;

  adc_capture_seq #(.N_CONV(N), .DW(DW), .START_CYC(STC), .ACC_CYC(ACC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .conv_cs_no(cs_n), .conv_wr_no(wr_n), .conv_rd_no(rd_n),
    .conv_sel_o(sel), .conv_data_i(din), .eoc_ni(eoc_n),
    .buf_we_o(we), .buf_addr_o(addr), .buf_data_o(bdata)
  );

  function automatic logic [DW-1:0] pat(int k, int r);
    return DW'((k * 29 + r * 7 + 3) & 8'hFF);
  endfunction

  assign din = (!rd_n && !cs_n) ? pat(int'(sel), run_id) : 8'h00;

  // converter model
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < N; i++) begin
      if (!wr_n) begin
        eoc_n[i] = 1'b1;
        cnt[i] = dly[i];
      end else if (cnt[i] != 0) begin
        cnt[i] = cnt[i] - 1;
        if (cnt[i] == 0) begin
          eoc_n[i] = 1'b0;
          last_fall = cyc;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_capture();
    int wr_low = 0, rd_low = 0, nwr = 0, ndone = 0, first_rd = -1, bad_cs = 0;
    int bad_addr = 0, bad_data = 0, done_ok = 0, post = 0;
    bit fin = 0;
    @(negedge clk); #1;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    for (int t = 0; t < 400 && !fin; t++) begin
      start = (t == 4 || t == 30);
      if (!wr_n) wr_low++;
      if (!wr_n && cs_n) bad_cs++;
      if (!rd_n) begin
        rd_low++;
        if (first_rd < 0) first_rd = cyc;
      end
      if (we) begin
        if (int'(addr) != nwr) bad_addr++;
        if (bdata != pat(int'(addr), run_id)) bad_data++;
        nwr++;
      end
      if (done) begin
        ndone++;
        if (we && addr == 3'(N - 1)) done_ok = 1;
        fin = 1;
      end
      @(negedge clk); #1;
    end
    start = 1'b0;
    for (int t = 0; t < 12; t++) begin
      if (!wr_n || we || done || !rd_n) post++;
      @(negedge clk); #1;
    end
    chk(wr_low == STC, "R2 strobe width", wr_low, STC);
    chk(bad_cs == 0, "R2 strobe without cs", bad_cs, 0);
    chk(first_rd == last_fall + 3, "R3 read start after last eoc", first_rd, last_fall + 3);
    chk(rd_low == N * ACC, "R4 read cycles", rd_low, N * ACC);
    chk(bad_data == 0, "R5 buffer data", bad_data, 0);
    chk(bad_addr == 0, "R8 addr order from 0", bad_addr, 0);
    chk(ndone == 1 && done_ok == 1, "R6 done pulse on last write", ndone, 1);
    chk(nwr == N, "R7 write count", nwr, N);
    chk(post == 0, "R7 idle after done", post, 0);
    run_id++;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      dly[i] = 8;
      cnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n && wr_n && rd_n, "R1 strobes idle high", {cs_n, wr_n, rd_n}, 7);
    chk(!done && !we, "R1 done/we low", {done, we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(wr_n && !we, "R7 no start without request", wr_n, 1);

    run_capture();
    for (int l = 0; l < N; l++) begin
      for (int i = 0; i < N; i++) dly[i] = (i == l) ? 20 + l : 6;
      run_capture();
    end
    for (int i = 0; i < N; i++) dly[i] = 6 + 2 * i;
    run_capture();
    for (int i = 0; i < N; i++) dly[i] = 6 + 2 * (N - 1 - i);
    run_capture();
    for (int i = 0; i < N; i++) dly[i] = 8;
    run_capture();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule